// File: doc/BRIEF.md
# 4:2:0 to 4:4:4 Chroma Upsampler

This block sits behind a video receiver that hands over a 4:2:0 pixel stream on a 48-bit bus at half the link rate. Each beat on that bus carries four luma samples and two chroma samples. The chroma component changes from line to line: lines with an even number carry blue-difference (Cb) samples, and lines with an odd number carry red-difference (Cr) samples. The block turns each beat into four complete 24-bit {Y, Cb, Cr} pixels.

The block tracks line parity from the vertical sync and the data-enable strobe. It keeps the chroma of the previous line in a block-RAM line buffer, indexed by beat position within the line. Each output pixel takes its chroma from two places. The component that belongs to the current line comes from the input, copied across both luma samples it covers. The other component comes from the buffer, at the same beat index. On the first line of a frame the buffer holds nothing valid, so the missing component is set to the mid-scale value.

The output sits behind two register stages. Valid and both syncs are delayed by the same amount, so downstream timing stays aligned.

Top module: `chroma_upsampler_420`

## Requirements
- R1: While reset is high, and on the first edge after it, out_valid, out_hsync, out_vsync and out_data are all zero.
- R2: out_valid, out_hsync and out_vsync equal in_valid, in_hsync and in_vsync as they were two rising edges earlier.
- R3: Input luma sits at bits 47:40 (Y0), 31:24 (Y1), 23:16 (Y2) and 7:0 (Y3). Output pixel n occupies bits 95-24n down to 72-24n, packed as {Y, Cb, Cr} with Y in the top byte. Pixel n carries Yn of the beat that entered two edges earlier.
- R4: Input chroma lane 0 (bits 39:32) is shared by pixels 0 and 1. Chroma lane 2 (bits 15:8) is shared by pixels 2 and 3. Within each pair, both pixels carry identical Cb and Cr.
- R5: On an even line, the current beat's chroma goes to the Cb field. On an odd line, it goes to the Cr field.
- R6: Line parity returns to even on every rising edge of in_vsync and toggles on every falling edge of in_valid. If both happen in the same cycle, the vsync rule wins.
- R7: On every line after the first of a frame, the other chroma field holds the chroma received at the same beat index and lane on the previous line.
- R8: On the first line after a rising edge of in_vsync (and after reset), the buffered chroma field is forced to 128.
- R9: When out_valid is low, out_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-bus clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Data enable, high on active beats |
| in_hsync | input | 1 | Horizontal sync, passed through with delay |
| in_vsync | input | 1 | Vertical sync; its rising edge starts a frame |
| in_data | input | 48 | Four luma and two chroma samples of one beat |
| out_valid | output | 1 | Delayed data enable |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_vsync | output | 1 | Delayed vertical sync |
| out_data | output | 96 | Four {Y, Cb, Cr} pixels, pixel 0 in the top 24 bits |

## Verification
The properties assume that every input is held at a defined level from the first clock after reset. They also assume that the active beats of consecutive lines within a frame have the same count, so every buffered read hits a location written on the line before. The stimulus meets both conditions: all inputs are driven to zero during reset, and every line of a frame has the same width. The frames differ in size, and one ends after an odd number of lines. That frame checks that a vsync edge, not the line count, decides the parity of the next frame.

// File: rtl/chroma420_pkg.sv
package chroma420_pkg;
  // Number of luma samples per input beat and chroma lanes per beat.
  localparam int LUMA_PER_BEAT   = 4;
  localparam int CHROMA_PER_BEAT = 2;

  // Mid-scale chroma for a sample width.
  function automatic logic [15:0] neutral_chroma(input int sw);
    return 16'(1) << (sw - 1);
  endfunction
endpackage

// File: rtl/chroma_line_parity.sv
module chroma_line_parity (
  input  logic clk,
  input  logic rst,
  input  logic de,
  input  logic vsync,
  output logic odd_line,
  output logic first_line
);
  logic de_q;
  logic vs_q;
  logic vs_rise;
  logic de_fall;

  assign vs_rise = vsync & ~vs_q;
  assign de_fall = ~de & de_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      de_q       <= 1'b0;
      vs_q       <= 1'b0;
      odd_line   <= 1'b0;
      first_line <= 1'b1;
    end else begin
      de_q <= de;
      vs_q <= vsync;
      if (vs_rise) begin
        odd_line   <= 1'b0;
        first_line <= 1'b1;
      end else if (de_fall) begin
        odd_line   <= ~odd_line;
        first_line <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/chroma_beat_index.sv
module chroma_beat_index #(
  parameter int DEPTH = 960,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          de,
  output logic [AW-1:0] idx
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (de) begin
      if (idx != LAST) idx <= idx + AW'(1);
    end else begin
      idx <= '0;
    end
  end
endmodule

// File: rtl/chroma_line_ram.sv
module chroma_line_ram #(
  parameter int DEPTH = 960,
  parameter int AW    = 10,
  parameter int W     = 16
) (
  input  logic          clk,
  input  logic          en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // Read-before-write: the read returns the previous line's entry.
  always_ff @(posedge clk) begin
    if (en) begin
      rdata     <= mem[addr];
      mem[addr] <= wdata;
    end
  end
endmodule

// File: rtl/chroma_pixel_pack.sv
module chroma_pixel_pack
  import chroma420_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             v_in,
  input  logic             hs_in,
  input  logic             vs_in,
  input  logic [6*SW-1:0]  beat,
  input  logic [2*SW-1:0]  prev_chroma,
  input  logic             odd_line,
  input  logic             first_line,
  output logic             v_out,
  output logic             hs_out,
  output logic             vs_out,
  output logic [12*SW-1:0] pix_out
);
  localparam int PIX_W = 3 * SW;
  localparam logic [SW-1:0] MID = SW'(neutral_chroma(SW));

  logic [SW-1:0] luma [LUMA_PER_BEAT];
  logic [SW-1:0] cur_c [CHROMA_PER_BEAT];
  logic [SW-1:0] old_c [CHROMA_PER_BEAT];
  logic [12*SW-1:0] packed_pix;

  assign luma[0]  = beat[6*SW-1:5*SW];
  assign luma[1]  = beat[4*SW-1:3*SW];
  assign luma[2]  = beat[3*SW-1:2*SW];
  assign luma[3]  = beat[SW-1:0];
  assign cur_c[0] = beat[5*SW-1:4*SW];
  assign cur_c[1] = beat[2*SW-1:SW];
  assign old_c[0] = first_line ? MID : prev_chroma[2*SW-1:SW];
  assign old_c[1] = first_line ? MID : prev_chroma[SW-1:0];

  for (genvar p = 0; p < LUMA_PER_BEAT; p++) begin : g_pix
    localparam int LANE = p / 2;
    logic [SW-1:0] cb;
    logic [SW-1:0] cr;
    assign cb = odd_line ? old_c[LANE] : cur_c[LANE];
    assign cr = odd_line ? cur_c[LANE] : old_c[LANE];
    assign packed_pix[12*SW-1-p*PIX_W -: PIX_W] = {luma[p], cb, cr};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_out   <= 1'b0;
      hs_out  <= 1'b0;
      vs_out  <= 1'b0;
      pix_out <= '0;
    end else begin
      v_out   <= v_in;
      hs_out  <= hs_in;
      vs_out  <= vs_in;
      pix_out <= v_in ? packed_pix : '0;
    end
  end
endmodule

// File: rtl/chroma_upsampler_420.sv
module chroma_upsampler_420 #(
  parameter int SW    = 8,
  parameter int DEPTH = 960
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_hsync,
  input  logic             in_vsync,
  input  logic [6*SW-1:0]  in_data,
  output logic             out_valid,
  output logic             out_hsync,
  output logic             out_vsync,
  output logic [12*SW-1:0] out_data
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int BUF_W = 2 * SW;

  logic          odd_line;
  logic          first_line;
  logic [AW-1:0] beat_idx;
  logic [BUF_W-1:0] buf_wr;
  logic [BUF_W-1:0] buf_rd;

  logic            s1_v;
  logic            s1_hs;
  logic            s1_vs;
  logic            s1_odd;
  logic            s1_first;
  logic [6*SW-1:0] s1_beat;

  chroma_line_parity u_parity (
    .clk        (clk),
    .rst        (rst),
    .de         (in_valid),
    .vsync      (in_vsync),
    .odd_line   (odd_line),
    .first_line (first_line)
  );

  chroma_beat_index #(.DEPTH(DEPTH), .AW(AW)) u_index (
    .clk (clk),
    .rst (rst),
    .de  (in_valid),
    .idx (beat_idx)
  );

  assign buf_wr = {in_data[5*SW-1:4*SW], in_data[2*SW-1:SW]};

  chroma_line_ram #(.DEPTH(DEPTH), .AW(AW), .W(BUF_W)) u_ram (
    .clk   (clk),
    .en    (in_valid),
    .addr  (beat_idx),
    .wdata (buf_wr),
    .rdata (buf_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v     <= 1'b0;
      s1_hs    <= 1'b0;
      s1_vs    <= 1'b0;
      s1_odd   <= 1'b0;
      s1_first <= 1'b1;
      s1_beat  <= '0;
    end else begin
      s1_v     <= in_valid;
      s1_hs    <= in_hsync;
      s1_vs    <= in_vsync;
      s1_odd   <= odd_line;
      s1_first <= first_line;
      s1_beat  <= in_data;
    end
  end

  chroma_pixel_pack #(.SW(SW)) u_pack (
    .clk         (clk),
    .rst         (rst),
    .v_in        (s1_v),
    .hs_in       (s1_hs),
    .vs_in       (s1_vs),
    .beat        (s1_beat),
    .prev_chroma (buf_rd),
    .odd_line    (s1_odd),
    .first_line  (s1_first),
    .v_out       (out_valid),
    .hs_out      (out_hsync),
    .vs_out      (out_vsync),
    .pix_out     (out_data)
  );
endmodule

// File: rtl/chroma_upsampler_420_chk.sv
module chroma_upsampler_420_chk #(
  parameter int SW = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_hsync,
  input logic             in_vsync,
  input logic [6*SW-1:0]  in_data,
  input logic             out_valid,
  input logic             out_hsync,
  input logic             out_vsync,
  input logic [12*SW-1:0] out_data
);
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_hsync && !out_vsync && out_data == '0));

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R2
  sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) |-> (out_hsync == $past(in_hsync, 2) && out_vsync == $past(in_vsync, 2)));

  // R3
  luma_route_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && out_valid) |->
      (out_data[12*SW-1 -: SW] == $past(in_data[6*SW-1 -: SW], 2) &&
       out_data[3*SW-1 -: SW]  == $past(in_data[SW-1:0], 2)));

  // R4
  chroma_pair_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |->
      (out_data[11*SW-1 -: 2*SW] == out_data[8*SW-1 -: 2*SW] &&
       out_data[5*SW-1 -: 2*SW]  == out_data[2*SW-1:0]));

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_data == '0));
endmodule

bind chroma_upsampler_420 chroma_upsampler_420_chk #(.SW(SW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_hsync  (in_hsync),
  .in_vsync  (in_vsync),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_hsync (out_hsync),
  .out_vsync (out_vsync),
  .out_data  (out_data)
);

// File: tb/chroma_upsampler_420_bench.sv
module chroma_upsampler_420_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_hsync = 1'b0;
  logic        in_vsync = 1'b0;
  logic [47:0] in_data = '0;
  logic        out_valid;
  logic        out_hsync;
  logic        out_vsync;
  logic [95:0] out_data;

  int checks = 0;
  int errors = 0;

  // Reference state: chroma of the previous line per beat and lane.
  int prev_c [0:63][0:1];

  // Two-deep expectation pipeline.
  logic        p0_v = 0, p0_hs = 0, p0_vs = 0, p0_odd = 0, p0_first = 0;
  logic [95:0] p0_d = '0;
  logic        p1_v = 0, p1_hs = 0, p1_vs = 0, p1_odd = 0, p1_first = 0;
  logic [95:0] p1_d = '0;

  always #5 clk = ~clk;

  chroma_upsampler_420 u_chroma_upsampler_420 (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_hsync  (in_hsync),
    .in_vsync  (in_vsync),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_hsync (out_hsync),
    .out_vsync (out_vsync),
    .out_data  (out_data)
  );

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk("R2 valid", 96'(out_valid), 96'(p1_v));
    chk("R2 hsync", 96'(out_hsync), 96'(p1_hs));
    chk("R2 vsync", 96'(out_vsync), 96'(p1_vs));
    if (!p1_v) begin
      chk("R9 idle data", out_data, 96'd0);
    end else begin
      for (int p = 0; p < 4; p++) begin
        int b;
        b = 95 - 24 * p;
        chk("R3 luma", 96'(out_data[b -: 8]), 96'(p1_d[b -: 8]));
        chk(p1_odd ? "R7 buffered Cb" : "R5 R6 current Cb",
            96'(out_data[b-8 -: 8]), 96'(p1_d[b-8 -: 8]));
        chk(p1_odd ? "R5 R6 current Cr" : (p1_first ? "R8 neutral Cr" : "R7 buffered Cr"),
            96'(out_data[b-16 -: 8]), 96'(p1_d[b-16 -: 8]));
      end
      chk("R4 pair 0/1", 96'(out_data[87:72]), 96'(out_data[63:48]));
      chk("R4 pair 2/3", 96'(out_data[39:24]), 96'(out_data[15:0]));
    end
  endtask

  task automatic step(input logic v, input logic hs, input logic vs, input logic [47:0] d,
                      input logic [95:0] ed, input logic odd, input logic first);
    @(negedge clk);
    compare();
    p1_v = p0_v; p1_hs = p0_hs; p1_vs = p0_vs; p1_d = p0_d; p1_odd = p0_odd; p1_first = p0_first;
    p0_v = v; p0_hs = hs; p0_vs = vs; p0_d = ed; p0_odd = odd; p0_first = first;
    in_valid = v; in_hsync = hs; in_vsync = vs; in_data = d;
  endtask

  task automatic idle(input logic hs, input logic vs);
    step(1'b0, hs, vs, 48'd0, 96'd0, 1'b0, 1'b0);
  endtask

  task automatic beat(input int fr, input int ln, input int bt);
    logic [7:0]  y [4];
    logic [7:0]  c [2];
    logic [7:0]  o [2];
    logic [7:0]  cb, cr;
    logic [47:0] d;
    logic [95:0] ed;
    for (int k = 0; k < 4; k++) y[k] = 8'((ln * 37 + bt * 11 + k * 5 + fr * 3) & 255);
    for (int k = 0; k < 2; k++) begin
      c[k] = 8'((ln * 53 + bt * 7 + k * 29 + fr * 17 + 1) & 255);
      o[k] = (ln == 0) ? 8'd128 : 8'(prev_c[bt][k]);
      prev_c[bt][k] = int'(c[k]);
    end
    d = {y[0], c[0], y[1], y[2], c[1], y[3]};
    for (int p = 0; p < 4; p++) begin
      cb = (ln % 2 == 1) ? o[p/2] : c[p/2];
      cr = (ln % 2 == 1) ? c[p/2] : o[p/2];
      ed[95 - 24 * p -: 24] = {y[p], cb, cr};
    end
    step(1'b1, 1'b0, 1'b0, d, ed, 1'(ln % 2), ln == 0);
  endtask

  task automatic frame(input int fr, input int lines, input int beats);
    idle(1'b0, 1'b1);
    idle(1'b0, 1'b1);
    idle(1'b0, 1'b0);
    for (int ln = 0; ln < lines; ln++) begin
      idle(1'b1, 1'b0);
      idle(1'b0, 1'b0);
      for (int bt = 0; bt < beats; bt++) beat(fr, ln, bt);
      idle(1'b0, 1'b0);
      idle(1'b0, 1'b0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs held at zero through reset
    chk("R1 valid", 96'(out_valid), 96'd0);
    chk("R1 syncs", 96'({out_hsync, out_vsync}), 96'd0);
    chk("R1 data", out_data, 96'd0);
    rst = 1'b0;
    for (int k = 0; k < 3; k++) idle(1'b0, 1'b0);
    frame(0, 4, 4);   // 16x4 frame
    frame(1, 3, 6);   // odd line count: next frame must restart even (R6)
    frame(2, 4, 4);
    frame(3, 2, 1);   // single-beat lines
    for (int k = 0; k < 4; k++) idle(1'b0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule